// File: doc/BRIEF.md
# Wide-to-Narrow Read Port Sizer

This block sits between the read side of a 36-bit first-word-fall-through FIFO and a narrow transmit port. Each 36-bit FIFO word is four 9-bit lanes, and each lane is 8 data bits (bits 7:0) plus one parity bit (bit 8). The block hands each word out either as two 18-bit pieces or as four 9-bit pieces. It can reverse the byte order in either width and can replace every parity bit with freshly generated odd parity.

A one-word holding stage is loaded from the FIFO. The narrow port takes one piece per rising clock edge when its read enable is high and `empty_o` is low. The next FIFO word is popped only when the holding stage is empty, or in the same cycle that the final piece of the held word is taken. When that happens, the next word follows with no gap. Width, order and parity settings are sampled once, on the first rising edge after reset is released, and stay fixed until the next reset.

Top module: `narrow_rd_port`

## Requirements
- R1: While `rst_ni` is low, and in the cycle before the first rising edge after its release, `empty_o`=1 and `fifo_pop_o`=0. The configuration inputs are sampled on that first edge: `byte_mode_i`=1 selects 9-bit pieces, `swap_i`=1 selects reversed order, and `par_gen_i`=1 selects parity generation.
- R2: In 18-bit mode each word yields two pieces on `data_o[17:0]`: first `word[35:18]`, then `word[17:0]`.
- R3: In 9-bit mode each word yields four pieces on `data_o[8:0]`, in the order `word[35:27]`, `word[26:18]`, `word[17:9]`, `word[8:0]`. `data_o[17:9]` is 0 in this mode.
- R4: Swap reverses the byte sequence. In 9-bit mode the order is `word[8:0]`, `word[17:9]`, `word[26:18]`, `word[35:27]`. In 18-bit mode the first piece is `{word[8:0],word[17:9]}` and the second is `{word[26:18],word[35:27]}`.
- R5: With parity generation on, bit 8 of every output lane equals the odd parity of that lane's bits 7:0, so it is 1 when those bits hold an even number of ones. With it off, bit 8 passes through unchanged.
- R6: A piece is taken at a rising edge where `rd_en_i`=1 and `empty_o`=0. Across an edge where `rd_en_i`=0, both `data_o` and `empty_o` hold their values.
- R7: `fifo_pop_o` is 1 only when `fifo_empty_i`=0, and only in a cycle where either `empty_o`=1 or the final piece of the held word is being taken. The first piece of the popped word is on `data_o`, with `empty_o`=0, after that edge.
- R8: When the final piece is taken while the FIFO holds data, `empty_o` stays 0 and the next word's first piece appears at the very next edge.
- R9: When the final piece is taken while the FIFO is empty, `empty_o` becomes 1 after that edge and stays 1 while `fifo_empty_i`=1.
- R10: Changes on `byte_mode_i`, `swap_i` or `par_gen_i` after the configuration has been sampled have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_mode_i | input | 1 | 1: 9-bit pieces, 0: 18-bit pieces (sampled after reset) |
| swap_i | input | 1 | 1: reversed byte order (sampled after reset) |
| par_gen_i | input | 1 | 1: generate odd parity on each lane (sampled after reset) |
| fifo_data_i | input | 36 | Head word of the FIFO |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_pop_o | output | 1 | Consume the FIFO head word at this edge |
| rd_en_i | input | 1 | Narrow port read enable |
| data_o | output | 18 | Current narrow piece |
| empty_o | output | 1 | No piece available |

## Verification
Two events can fall on the same edge: the narrow port taking the final piece of a word, and the holding stage loading the next FIFO word. The bench provokes this by preloading several words and reading with `rd_en_i` held high, both continuously and with stalls. It then judges the result at the ports in three ways. Every pop must fall on a final-piece read. No empty cycle may appear between words. The collected pieces must match, in order, the stream computed from the pushed words.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  typedef struct packed {
    logic byte_mode;
    logic swap;
    logic par_gen;
  } bsz_cfg_t;
endpackage

// File: rtl/bsz_cfg_latch.sv
module bsz_cfg_latch
  import bsz_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bsz_cfg_t cfg_i,
  output bsz_cfg_t cfg_o,
  output logic     ready_o
);
  bsz_cfg_t cfg_q;
  logic     ready_q;

  // sample once on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      cfg_q   <= cfg_i;
      ready_q <= 1'b1;
    end
  end

  assign cfg_o   = cfg_q;
  assign ready_o = ready_q;
endmodule

// File: rtl/bsz_seq.sv
module bsz_seq #(
  parameter int LANE_W    = 9,
  parameter int LANES     = 4,
  parameter int OUT_LANES = 2,
  localparam int WORD_W   = LANE_W * LANES,
  localparam int PIECE_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ready_i,
  input  logic               byte_mode_i,
  input  logic [WORD_W-1:0]  fifo_data_i,
  input  logic               fifo_empty_i,
  input  logic               rd_en_i,
  output logic               fifo_pop_o,
  output logic [WORD_W-1:0]  word_o,
  output logic [PIECE_W-1:0] piece_o,
  output logic               valid_o
);
  localparam logic [PIECE_W-1:0] LAST_BYTE = PIECE_W'(LANES - 1);
  localparam logic [PIECE_W-1:0] LAST_WIDE = PIECE_W'(LANES / OUT_LANES - 1);

  logic [WORD_W-1:0]  word_q;
  logic [PIECE_W-1:0] cnt_q;
  logic               valid_q;
  logic               take, fin, load;
  logic [PIECE_W-1:0] last_idx;

  assign last_idx = byte_mode_i ? LAST_BYTE : LAST_WIDE;
  assign take     = valid_q & rd_en_i;
  assign fin      = take & (cnt_q == last_idx);
  // refill on an idle stage or in the same cycle the final piece leaves
  assign load     = ready_i & ~fifo_empty_i & (~valid_q | fin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (load) begin
      word_q  <= fifo_data_i;
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (fin) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (take) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign fifo_pop_o = load;
  assign word_o     = word_q;
  assign piece_o    = cnt_q;
  assign valid_o    = valid_q;
endmodule

// File: rtl/bsz_lane_mux.sv
module bsz_lane_mux
  import bsz_pkg::*;
#(
  parameter int LANE_W    = 9,
  parameter int LANES     = 4,
  parameter int OUT_LANES = 2,
  localparam int WORD_W   = LANE_W * LANES,
  localparam int OUT_W    = LANE_W * OUT_LANES,
  localparam int PIECE_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  bsz_cfg_t           cfg_i,
  input  logic [WORD_W-1:0]  word_i,
  input  logic [PIECE_W-1:0] piece_i,
  output logic [OUT_W-1:0]   data_o
);
  for (genvar l = 0; l < OUT_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] raw;
    logic [LANE_W-1:0] lane_v;
    logic              used;
    int                pos;
    int                idx;

    always_comb begin
      if (cfg_i.byte_mode) begin
        used = (l == 0);
        pos  = int'(piece_i);
      end else begin
        used = 1'b1;
        // top lane carries the earlier byte of the stream
        pos  = int'(piece_i) * OUT_LANES + (OUT_LANES - 1 - l);
      end
      idx = cfg_i.swap ? pos : (LANES - 1 - pos);
      raw = word_i[idx*LANE_W +: LANE_W];
      if (cfg_i.par_gen) raw[LANE_W-1] = ~^raw[LANE_W-2:0];
      lane_v = used ? raw : '0;
    end

    assign data_o[l*LANE_W +: LANE_W] = lane_v;
  end
endmodule

// File: rtl/narrow_rd_port.sv
module narrow_rd_port
  import bsz_pkg::*;
#(
  parameter int LANE_W    = 9,
  parameter int LANES     = 4,
  parameter int OUT_LANES = 2,
  localparam int WORD_W   = LANE_W * LANES,
  localparam int OUT_W    = LANE_W * OUT_LANES,
  localparam int PIECE_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_mode_i,
  input  logic              swap_i,
  input  logic              par_gen_i,
  input  logic [WORD_W-1:0] fifo_data_i,
  input  logic              fifo_empty_i,
  output logic              fifo_pop_o,
  input  logic              rd_en_i,
  output logic [OUT_W-1:0]  data_o,
  output logic              empty_o
);
  bsz_cfg_t           cfg_in, cfg_q;
  logic               cfg_ready;
  logic [WORD_W-1:0]  word;
  logic [PIECE_W-1:0] piece;
  logic               valid;

  assign cfg_in = '{byte_mode: byte_mode_i, swap: swap_i, par_gen: par_gen_i};

  bsz_cfg_latch i_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_q),
    .ready_o(cfg_ready)
  );

  bsz_seq #(.LANE_W(LANE_W), .LANES(LANES), .OUT_LANES(OUT_LANES)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (cfg_ready),
    .byte_mode_i (cfg_q.byte_mode),
    .fifo_data_i (fifo_data_i),
    .fifo_empty_i(fifo_empty_i),
    .rd_en_i     (rd_en_i),
    .fifo_pop_o  (fifo_pop_o),
    .word_o      (word),
    .piece_o     (piece),
    .valid_o     (valid)
  );

  bsz_lane_mux #(.LANE_W(LANE_W), .LANES(LANES), .OUT_LANES(OUT_LANES)) i_mux (
    .cfg_i  (cfg_q),
    .word_i (word),
    .piece_i(piece),
    .data_o (data_o)
  );

  assign empty_o = ~valid;
endmodule

// File: rtl/narrow_rd_port_chk.sv
module narrow_rd_port_chk
  import bsz_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int OUT_W  = 18
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fifo_empty_i,
  input logic             fifo_pop_o,
  input logic             rd_en_i,
  input logic [OUT_W-1:0] data_o,
  input logic             empty_o,
  input bsz_cfg_t         cfg_q,
  input logic             cfg_ready
);
  assert_pop_nonempty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);

  assert_pop_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_pop_o && !empty_o) |-> rd_en_i);

  assert_pop_loads_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |=> !empty_o);

  assert_stall_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !rd_en_i) |=> (!empty_o && $stable(data_o)));

  assert_empty_stays_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && fifo_empty_i) |=> empty_o);

  assert_no_early_pop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_ready |-> (empty_o && !fifo_pop_o));

  assert_parity_gen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ready && cfg_q.par_gen && !empty_o) |->
      (data_o[LANE_W-1] == ~^data_o[LANE_W-2:0]));

  assert_byte_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_ready && cfg_q.byte_mode && !empty_o) |-> (data_o[OUT_W-1:LANE_W] == '0));
endmodule

bind narrow_rd_port narrow_rd_port_chk #(.LANE_W(LANE_W), .OUT_W(OUT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fifo_empty_i(fifo_empty_i),
  .fifo_pop_o  (fifo_pop_o),
  .rd_en_i     (rd_en_i),
  .data_o      (data_o),
  .empty_o     (empty_o),
  .cfg_q       (cfg_q),
  .cfg_ready   (cfg_ready)
);

// File: tb/test_narrow_rd_port.sv
module test_narrow_rd_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_mode = 1'b0, swap = 1'b0, par_gen = 1'b0;
  logic [35:0] fifo_data = '0;
  logic        fifo_empty = 1'b1;
  logic        fifo_pop;
  logic        rd_en = 1'b0;
  logic [17:0] data;
  logic        empty;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [35:0] q[$];
  logic [17:0] got[$];
  logic [17:0] exp_q[$];
  bit          prev_hold = 0;
  logic [17:0] prev_data = '0;
  int          ppw = 2;
  int          bad_pop = 0, bubbles = 0, bad_hold = 0;

  always #5 clk = ~clk;

  narrow_rd_port i_narrow_rd_port (
    .clk_i(clk), .rst_ni(rst_ni), .byte_mode_i(byte_mode), .swap_i(swap),
    .par_gen_i(par_gen), .fifo_data_i(fifo_data), .fifo_empty_i(fifo_empty),
    .fifo_pop_o(fifo_pop), .rd_en_i(rd_en), .data_o(data), .empty_o(empty)
  );

  task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic logic [8:0] lane_of(logic [35:0] w, int pos, bit sw, bit pg);
    int idx = sw ? pos : 3 - pos;
    logic [8:0] l = w[9*idx +: 9];
    if (pg) l[8] = ~^l[7:0];
    return l;
  endfunction

  function automatic logic [17:0] exp_piece(logic [35:0] w, int p, bit bm, bit sw, bit pg);
    if (bm) return {9'b0, lane_of(w, p, sw, pg)};
    return {lane_of(w, 2*p, sw, pg), lane_of(w, 2*p+1, sw, pg)};
  endfunction

  task automatic refresh();
    fifo_empty = (q.size() == 0);
    fifo_data  = (q.size() != 0) ? q[0] : '0;
  endtask

  task automatic step();
    bit popped;
    @(negedge clk);
    if (prev_hold && (empty || data != prev_data)) bad_hold++;
    if (fifo_pop && !empty && !(rd_en && (got.size() % ppw) == ppw - 1)) bad_pop++;
    if (got.size() > 0 && got.size() < exp_q.size() && empty) bubbles++;
    prev_hold = !empty && !rd_en;
    prev_data = data;
    if (rd_en && !empty) got.push_back(data);
    popped = fifo_pop;
    @(posedge clk);
    #1;
    if (popped && q.size() != 0) void'(q.pop_front());
    refresh();
  endtask

  task automatic do_reset(input bit bm, input bit sw, input bit pg);
    rst_ni = 1'b0;
    rd_en = 1'b0;
    byte_mode = bm; swap = sw; par_gen = pg;
    q.delete(); got.delete(); exp_q.delete();
    prev_hold = 0; bad_pop = 0; bubbles = 0; bad_hold = 0;
    ppw = bm ? 4 : 2;
    refresh();
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  task automatic drain(input bit bm, input bit sw, input bit pg, input int nw,
                       input bit stall, input string req);
    int k = 0;
    int mism = 0;
    for (int i = 0; i < nw; i++) begin
      logic [35:0] w = {$urandom, $urandom};
      q.push_back(w);
      for (int p = 0; p < (bm ? 4 : 2); p++) exp_q.push_back(exp_piece(w, p, bm, sw, pg));
    end
    refresh();
    while (got.size() < exp_q.size() && k < 400) begin
      rd_en = stall ? (k % 3 != 1) : 1'b1;
      step();
      k++;
    end
    rd_en = 1'b0;
    check(got.size() == exp_q.size(), {req, " piece count"}, got.size(), exp_q.size());
    for (int i = 0; i < got.size() && i < exp_q.size(); i++)
      if (got[i] !== exp_q[i]) begin
        if (mism == 0) check(0, {req, " piece data"}, got[i], exp_q[i]);
        mism++;
      end
    if (mism == 0) check(1, req, 0, 0);
    check(bad_pop == 0, "R7 pop only on final piece", bad_pop, 0);
    check(bubbles == 0, "R8 no empty gap between words", bubbles, 0);
    @(negedge clk);
    check(empty === 1'b1, "R9 empty after final piece", empty, 1);
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0);
    rst_ni = 1'b0;
    q.push_back(36'h123456789);
    refresh();
    @(negedge clk);
    check(empty === 1'b1 && fifo_pop === 1'b0, "R1 outputs in reset", {empty, fifo_pop}, 2'b10);
    @(posedge clk); #1 rst_ni = 1'b1;
    @(negedge clk);
    check(empty === 1'b1 && fifo_pop === 1'b0, "R1 first cycle after release", {empty, fifo_pop}, 2'b10);
    @(posedge clk); #1;
    @(negedge clk);
    check(fifo_pop === 1'b1 && empty === 1'b1, "R7 pop into idle stage", {empty, fifo_pop}, 2'b11);
    @(posedge clk); #1; void'(q.pop_front()); refresh();
    @(negedge clk);
    check(empty === 1'b0 && data === 18'h048D1, "R2 first piece after pop", data, 18'h048D1);
  endtask

  task automatic t_word_plain();
    do_reset(0, 0, 0);
    drain(0, 0, 0, 5, 0, "R2 word order");
  endtask

  task automatic t_word_swap();
    do_reset(0, 1, 0);
    drain(0, 1, 0, 5, 0, "R4 word swap");
  endtask

  task automatic t_byte_plain();
    do_reset(1, 0, 0);
    drain(1, 0, 0, 4, 0, "R3 byte order");
  endtask

  task automatic t_byte_swap();
    do_reset(1, 1, 0);
    drain(1, 1, 0, 4, 0, "R4 byte swap");
  endtask

  task automatic t_parity();
    do_reset(0, 0, 1);
    drain(0, 0, 1, 4, 0, "R5 parity word mode");
    do_reset(1, 1, 1);
    drain(1, 1, 1, 3, 0, "R5 parity byte swap");
  endtask

  task automatic t_stall();
    do_reset(1, 0, 0);
    drain(1, 0, 0, 4, 1, "R6 stalled reads");
    check(bad_hold == 0, "R6 hold across idle edge", bad_hold, 0);
  endtask

  task automatic t_cfg_ignore();
    do_reset(0, 0, 0);
    repeat (2) @(posedge clk);
    #1 byte_mode = 1'b1; swap = 1'b1; par_gen = 1'b1;
    drain(0, 0, 0, 3, 0, "R10 late config ignored");
  endtask

  task automatic t_refill();
    do_reset(0, 0, 0);
    drain(0, 0, 0, 1, 0, "R2 single word");
    for (int i = 0; i < 3; i++) step();
    @(negedge clk);
    check(empty === 1'b1, "R9 empty holds while fifo empty", empty, 1);
    @(posedge clk); #1;
    q.push_back(36'h0FF00AA55);
    refresh();
    @(negedge clk);
    check(empty === 1'b1 && fifo_pop === 1'b1, "R7 refill pop", {empty, fifo_pop}, 2'b11);
    @(posedge clk); #1; void'(q.pop_front()); refresh();
    @(negedge clk);
    check(empty === 1'b0 && data === exp_piece(36'h0FF00AA55, 0, 0, 0, 0), "R7 refill data",
          data, exp_piece(36'h0FF00AA55, 0, 0, 0, 0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    t_reset();
    t_word_plain();
    t_word_swap();
    t_byte_plain();
    t_byte_swap();
    t_parity();
    t_stall();
    t_cfg_ignore();
    t_refill();
    done = 1;
    summary();
  end
endmodule